// File: doc/BRIEF.md
# Two-Stage Receive Gain Controller

This block holds the receive path gain setting and turns it into control values for two cascaded amplifiers, a coarse stage and a fine stage. The setting is a 5-bit code whose total gain runs from -6 dB to 36 dB in 2 dB steps. The code arrives by one of two routes: a register write, or a load from five transmit data pins that a gain strobe qualifies. A source-select input decides which route is live. The route that is not selected is ignored.

A wideband-filter mode limits the total gain to 30 dB. In that mode the four highest codes all map to the same split between the stages. The stored code is always shown on a readback port, whichever route wrote it. The stage values come out as signed dB integers, registered together with the code.

Top module: `rx_gain_ctrl`

## Requirements
- R1: After reset the readback code is 0, the coarse stage is -6 dB, the fine stage is 0 dB and the total is -6 dB.
- R2: With `gain_src_reg` high, a cycle with `reg_wr_en` high stores `reg_wr_code`. The stored code shows on `gain_readback` one clock after that edge.
- R3: With `gain_src_reg` low, a cycle with `gain_strobe` high stores `tx_pins`, which are the five MSB-aligned transmit pins (pin 5 is the code MSB). The stored code shows on `gain_readback` one clock after that edge.
- R4: The write path that is not selected has no effect. In a cycle where the selected path is idle, the code is held.
- R5: A code above 21 (0x15) from either path is stored and read back as 21.
- R6: Codes 0 to 5 give coarse -6 dB and fine 2*code dB.
- R7: Codes 6 to 17 give coarse 6*((code-6)/3) dB and fine 6+2*((code-6) mod 3) dB.
- R8: With `wideband_en` low, codes 18 to 21 give coarse 24 dB and fine 6+2*(code-18) dB.
- R9: With `wideband_en` high, codes 18 to 21 give coarse 18 dB, fine 12 dB and total 30 dB. The readback still shows the stored code.
- R10: `total_db` equals coarse plus fine. Outside the wideband cap it is -6+2*code.
- R11: Changing `gain_src_reg` alone leaves the applied code and the stage values unchanged.
- R12: A change of `wideband_en` alone reaches the stage outputs one clock later, with no new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gain_src_reg | input | 1 | 1: register path is live, 0: pin path is live |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_code | input | CODE_W | Code from a register write |
| gain_strobe | input | 1 | Gain strobe for the pin path |
| tx_pins | input | CODE_W | Five MSB-aligned transmit data pins |
| wideband_en | input | 1 | Wideband filter mode, caps total at 30 dB |
| gain_readback | output | CODE_W | Applied gain code |
| coarse_db | output | DB_W | Coarse stage gain, signed dB |
| fine_db | output | DB_W | Fine stage gain, signed dB |
| total_db | output | DB_W | Total applied gain, signed dB |

## Verification
All results come from one register rank. A write, or a change of `wideband_en`, that is present at one rising edge shows on every output right after that edge. The bench drives inputs on the falling edge and samples on the next falling edge, so it reads the result exactly one clock after the input is seen. It sweeps all 32 input codes through both paths and in both filter modes. Checks for ignored writes and for source switches read the outputs in the cycle right after the stimulus, before anything else changes.

// File: rtl/rx_gain_pkg.sv
package rx_gain_pkg;
    localparam int GAIN_CODE_W = 5;
    localparam int GAIN_DB_W   = 7;
    localparam int LOW_TOP     = 5;   // last code with coarse stage at minimum
    localparam int MID_TOP     = 17;  // last code of the three-per-step region
    localparam int CODE_MAX    = 21;  // highest legal code
    localparam int COARSE_MIN  = -6;
    localparam int WB_COARSE   = 18;
    localparam int WB_FINE     = 12;
    localparam int HI_COARSE   = 24;
endpackage

// File: rtl/rx_gain_src.sv
module rx_gain_src #(
    parameter int CODE_W   = 5,
    parameter int CODE_LIM = 21
) (
    input  logic              sel_reg,
    input  logic              reg_wr_en,
    input  logic [CODE_W-1:0] reg_code,
    input  logic              strobe,
    input  logic [CODE_W-1:0] pins,
    output logic              load,
    output logic [CODE_W-1:0] load_code
);
    localparam int RAW_MAX = (1 << CODE_W) - 1;

    logic [CODE_W-1:0] raw_code;

    always_comb begin
        if (sel_reg) begin
            load     = reg_wr_en;
            raw_code = reg_code;
        end else begin
            load     = strobe;
            raw_code = pins;
        end
    end

    generate
        if (CODE_LIM < RAW_MAX) begin : g_clip
            always_comb begin
                if (int'(raw_code) > CODE_LIM) load_code = CODE_W'(CODE_LIM);
                else                           load_code = raw_code;
            end
        end else begin : g_pass
            assign load_code = raw_code;
        end
    endgenerate
endmodule

// File: rtl/rx_gain_map.sv
module rx_gain_map
    import rx_gain_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int DB_W   = 7
) (
    input  logic                   [CODE_W-1:0] code,
    input  logic                                wideband,
    output logic signed            [DB_W-1:0]   coarse,
    output logic signed            [DB_W-1:0]   fine,
    output logic signed            [DB_W-1:0]   total
);
    int c;
    int cg;
    int fg;
    int tg;

    always_comb begin
        c  = int'(code);
        cg = COARSE_MIN;
        fg = 0;
        if (c <= LOW_TOP) begin
            cg = COARSE_MIN;
            fg = 2 * c;
        end else if (c <= MID_TOP) begin
            cg = 6 * ((c - (LOW_TOP + 1)) / 3);
            fg = 6 + 2 * ((c - (LOW_TOP + 1)) % 3);
        end else if (wideband) begin
            cg = WB_COARSE;
            fg = WB_FINE;
        end else begin
            cg = HI_COARSE;
            fg = 6 + 2 * (c - (MID_TOP + 1));
        end
        // total follows the code ramp, capped separately in wideband mode
        if (wideband && c > MID_TOP) tg = WB_COARSE + WB_FINE;
        else                         tg = COARSE_MIN + 2 * c;
        coarse = DB_W'(cg);
        fine   = DB_W'(fg);
        total  = DB_W'(tg);
    end
endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
    import rx_gain_pkg::*;
#(
    parameter int CODE_W = GAIN_CODE_W,
    parameter int DB_W   = GAIN_DB_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     gain_src_reg,
    input  logic                     reg_wr_en,
    input  logic [CODE_W-1:0]        reg_wr_code,
    input  logic                     gain_strobe,
    input  logic [CODE_W-1:0]        tx_pins,
    input  logic                     wideband_en,
    output logic [CODE_W-1:0]        gain_readback,
    output logic signed [DB_W-1:0]   coarse_db,
    output logic signed [DB_W-1:0]   fine_db,
    output logic signed [DB_W-1:0]   total_db
);
    typedef struct packed {
        logic [CODE_W-1:0]      code;
        logic signed [DB_W-1:0] coarse;
        logic signed [DB_W-1:0] fine;
        logic signed [DB_W-1:0] total;
    } gain_state_t;

    gain_state_t state_d, state_q;

    logic                   load;
    logic [CODE_W-1:0]      load_code;
    logic signed [DB_W-1:0] map_coarse;
    logic signed [DB_W-1:0] map_fine;
    logic signed [DB_W-1:0] map_total;

    rx_gain_src #(
        .CODE_W   (CODE_W),
        .CODE_LIM (CODE_MAX)
    ) u_src (
        .sel_reg   (gain_src_reg),
        .reg_wr_en (reg_wr_en),
        .reg_code  (reg_wr_code),
        .strobe    (gain_strobe),
        .pins      (tx_pins),
        .load      (load),
        .load_code (load_code)
    );

    rx_gain_map #(
        .CODE_W (CODE_W),
        .DB_W   (DB_W)
    ) u_map (
        .code     (state_d.code),
        .wideband (wideband_en),
        .coarse   (map_coarse),
        .fine     (map_fine),
        .total    (map_total)
    );

    always_comb begin
        state_d = state_q;
        if (load) state_d.code = load_code;
        state_d.coarse = map_coarse;
        state_d.fine   = map_fine;
        state_d.total  = map_total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.code   <= '0;
            state_q.coarse <= DB_W'(COARSE_MIN);
            state_q.fine   <= '0;
            state_q.total  <= DB_W'(COARSE_MIN);
        end else begin
            state_q <= state_d;
        end
    end

    assign gain_readback = state_q.code;
    assign coarse_db     = state_q.coarse;
    assign fine_db       = state_q.fine;
    assign total_db      = state_q.total;
endmodule

// File: rtl/rx_gain_ctrl_chk.sv
module rx_gain_ctrl_chk #(
    parameter int CODE_W = 5,
    parameter int DB_W   = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   gain_src_reg,
    input logic                   reg_wr_en,
    input logic [CODE_W-1:0]      reg_wr_code,
    input logic                   gain_strobe,
    input logic [CODE_W-1:0]      tx_pins,
    input logic                   wideband_en,
    input logic [CODE_W-1:0]      gain_readback,
    input logic signed [DB_W-1:0] coarse_db,
    input logic signed [DB_W-1:0] fine_db,
    input logic signed [DB_W-1:0] total_db
);
    AST_CODE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gain_readback) <= 21); // R5

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        gain_src_reg && reg_wr_en |=>
        int'(gain_readback) == ((int'($past(reg_wr_code)) > 21) ? 21 : int'($past(reg_wr_code)))); // R2

    AST_PIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_src_reg && gain_strobe |=>
        int'(gain_readback) == ((int'($past(tx_pins)) > 21) ? 21 : int'($past(tx_pins)))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_src_reg ? !reg_wr_en : !gain_strobe) |=> $stable(gain_readback)); // R4

    AST_WB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        wideband_en |=> total_db <= 30); // R9

    AST_STAGE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        total_db == coarse_db + fine_db); // R10

    AST_LOW_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gain_readback) <= 5 |-> coarse_db == -6); // R6
endmodule

bind rx_gain_ctrl rx_gain_ctrl_chk #(.CODE_W(CODE_W), .DB_W(DB_W)) u_chk (.*);

// File: tb/rx_gain_ctrl_bench.sv
`timescale 1ns/1ps
module rx_gain_ctrl_bench;
    localparam int CW = 5;
    localparam int DW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gain_src_reg = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [CW-1:0] reg_wr_code = '0;
    logic          gain_strobe = 1'b0;
    logic [CW-1:0] tx_pins = '0;
    logic          wideband_en = 1'b0;
    logic [CW-1:0]        gain_readback;
    logic signed [DW-1:0] coarse_db;
    logic signed [DW-1:0] fine_db;
    logic signed [DW-1:0] total_db;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_gain_ctrl u_rx_gain_ctrl (
        .clk, .rst_n, .gain_src_reg, .reg_wr_en, .reg_wr_code,
        .gain_strobe, .tx_pins, .wideband_en,
        .gain_readback, .coarse_db, .fine_db, .total_db
    );

    function automatic int clip(input int c);
        return (c > 21) ? 21 : c;
    endfunction

    // expected stages from the requirement text, written as a step walk
    function automatic void expect_db(input int c, input bit wb,
                                      output int ec, output int ef, output int et);
        ec = -6; ef = 0;
        for (int k = 0; k < c; k++) begin
            if (k < 5)       ef += 2;
            else if (k == 5) begin ec = 0; ef = 6; end
            else if (k < 17) begin
                if (ef == 10) begin ec += 6; ef = 6; end
                else ef += 2;
            end else if (k == 17) begin ec = 24; ef = 6; end
            else ef += 2;
        end
        if (wb && c >= 18) begin ec = 18; ef = 12; end
        et = ec + ef;
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic chk_all(input string req, input int c, input bit wb);
        int ec, ef, et;
        expect_db(c, wb, ec, ef, et);
        chk({req, " code"},   int'(gain_readback), c);
        chk({req, " coarse"}, int'(coarse_db), ec);
        chk({req, " fine"},   int'(fine_db), ef);
        chk({req, " total"},  int'(total_db), et);
    endtask

    // drive at falling edge, result due one rising edge later
    task automatic wr(input bit via_reg, input int c);
        @(negedge clk);
        gain_src_reg = via_reg;
        if (via_reg) begin reg_wr_en = 1'b1; reg_wr_code = CW'(c); end
        else         begin gain_strobe = 1'b1; tx_pins = CW'(c); end
        @(negedge clk);
        reg_wr_en = 1'b0;
        gain_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 0, 1'b0);

        // sweep every code through both paths, both filter modes
        for (int wb = 0; wb < 2; wb++) begin
            for (int src = 0; src < 2; src++) begin
                for (int c = 0; c < 32; c++) begin
                    wideband_en = wb[0];
                    wr(src[0], c);
                    if (c > 21)      chk_all("R5", clip(c), wb[0]);
                    else if (c >= 18) chk_all(wb ? "R9" : "R8", c, wb[0]);
                    else if (c >= 6)  chk_all("R7", c, wb[0]);
                    else              chk_all("R6", c, wb[0]);
                    if (src == 1) chk("R2 path", int'(gain_readback), clip(c));
                    else          chk("R3 path", int'(gain_readback), clip(c));
                    if (!(wb == 1 && c >= 18))
                        chk("R10 ramp", int'(total_db), -6 + 2 * clip(c));
                end
            end
        end

        // R4: unselected path ignored
        wideband_en = 1'b0;
        wr(1'b1, 9);
        @(negedge clk);
        gain_strobe = 1'b1; tx_pins = 5'd3;
        @(negedge clk);
        gain_strobe = 1'b0;
        chk_all("R4 strobe ignored", 9, 1'b0);
        wr(1'b0, 12);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_code = 5'd2;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk_all("R4 reg ignored", 12, 1'b0);

        // R11: source switch alone keeps gain
        wr(1'b1, 7);
        @(negedge clk);
        gain_src_reg = 1'b0;
        @(negedge clk);
        chk_all("R11 to pin", 7, 1'b0);
        gain_src_reg = 1'b1;
        @(negedge clk);
        chk_all("R11 to reg", 7, 1'b0);

        // R12: wideband toggle without rewrite
        wr(1'b1, 20);
        chk_all("R12 normal", 20, 1'b0);
        @(negedge clk);
        wideband_en = 1'b1;
        @(negedge clk);
        chk_all("R12 capped", 20, 1'b1);
        chk("R9 readback", int'(gain_readback), 20);
        wideband_en = 1'b0;
        @(negedge clk);
        chk_all("R12 uncapped", 20, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule